// File: doc/BRIEF.md
# Multi-Polynomial Byte-Serial CRC Engine

This block keeps a running cyclic redundancy checksum over a stream of data words. The host picks one of three generator polynomials and loads a starting value. It then writes words of 8, 16 or 32 bits. Each clock, one byte of the current word is folded into the checksum register. The first byte is folded on the clock edge that accepts the word. Any further bytes follow on the next edges, and the write port reports itself not ready while they do.

Each byte can be bit-reversed and complemented on its way in. The readout can be reversed and complemented across the active checksum width. These options cover both the reflected and the non-reflected conventions, and also final inversion. The readout is combinational from the checksum register, so it is valid in every cycle. Loading a new seed discards any bytes of a word that are still waiting.

Top module: `crc_engine`

## Requirements
- R1: `cfg_poly` selects the generator: code 0 is x^16+x^12+x^5+1, code 1 is x^16+x^15+x^2+1, and codes 2 and 3 are the 32-bit generator 0x04C11DB7. Each input bit is folded in MSB-first order: feedback = register top bit XOR data bit, then shift left by one, then XOR the generator if the feedback bit is 1.
- R2: `wr_size` code 0 carries `wr_data[7:0]`, code 1 carries `wr_data[15:0]`, and codes 2 and 3 carry all 32 bits. The bytes of a word are folded least-significant byte first.
- R3: Exactly one byte is folded per clock. The first byte is folded on the accepting edge, and `busy` is then high for exactly N-1 cycles for an N-byte word.
- R4: `wr_ready` is low while `busy` is high and while `seed_we` is high. A write held on the port while not ready stalls, and it is accepted and folded in full once ready returns.
- R5: A `seed_we` cycle loads `seed_val`, masked to the active width, into the checksum register. Any bytes still pending are dropped, and `busy` is low in the next cycle.
- R6: With `cfg_din_rev` set, each byte's bit order is reversed before folding. With `cfg_din_inv` set, each byte is complemented before folding.
- R7: `crc_out` is combinational from the register. With `cfg_sum_rev` set, bit order is reversed across the active width (16 or 32 bits). With `cfg_sum_inv` set, the active width is complemented.
- R8: With a 16-bit generator selected, only the low 16 register bits take part, and `crc_out[31:16]` reads zero.
- R9: After reset, the checksum register is zero, `busy` is low and `wr_ready` is high.
- R10: The checksum register changes only on a seed load or on a fold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_poly | input | 2 | Generator select |
| cfg_din_rev | input | 1 | Reverse bit order of each input byte |
| cfg_din_inv | input | 1 | Complement each input byte |
| cfg_sum_rev | input | 1 | Reverse readout across active width |
| cfg_sum_inv | input | 1 | Complement readout across active width |
| seed_we | input | 1 | Load seed and abort pending bytes |
| seed_val | input | 32 | Seed value |
| wr_valid | input | 1 | Data word offered |
| wr_ready | output | 1 | Data word can be accepted |
| wr_size | input | 2 | Word size code |
| wr_data | input | 32 | Data word |
| busy | output | 1 | Bytes of an accepted word remain |
| crc_out | output | 32 | Conditioned checksum readout |

## Verification
Several properties are checked on every cycle. The pending-byte counter must load N-1 on a 32-bit accept and count down by one per busy cycle. A seed load must always clear `busy`. The register must stay unchanged when neither a fold nor a seed load occurs. The upper readout half must stay zero under a 16-bit generator. The checksum values themselves can only be shown by the bench's scenarios, because they need an independent bit-serial model. These scenarios cover the arithmetic of each generator, the byte order, the reversal and inversion options, lossless stalls and the abort on seeding, plus well-known check values for the nine-byte ASCII string "123456789".

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int DATA_W   = 32;
  localparam int LANE_W   = 8;
  localparam int LANES    = DATA_W / LANE_W;
  localparam int CNT_W    = $clog2(LANES);
  localparam int HOLD_W   = DATA_W - LANE_W;
  localparam int NARROW_W = 16;

  localparam logic [1:0] SEL_CCITT = 2'd0;
  localparam logic [1:0] SEL_ANSI  = 2'd1;
  localparam logic [1:0] SZ_ONE    = 2'd0;
  localparam logic [1:0] SZ_TWO    = 2'd1;

  localparam logic [DATA_W-1:0] GEN_CCITT = 32'h0000_1021;
  localparam logic [DATA_W-1:0] GEN_ANSI  = 32'h0000_8005;
  localparam logic [DATA_W-1:0] GEN_WIDE  = 32'h04C1_1DB7;

  function automatic logic sel_wide(input logic [1:0] sel);
    return sel[1];
  endfunction

  function automatic logic [DATA_W-1:0] sel_mask(input logic [1:0] sel);
    logic [DATA_W-1:0] m;
    m = '0;
    if (sel_wide(sel)) m = '1;
    else               m[NARROW_W-1:0] = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] sel_gen(input logic [1:0] sel);
    logic [DATA_W-1:0] g;
    case (sel)
      SEL_CCITT: g = GEN_CCITT;
      SEL_ANSI:  g = GEN_ANSI;
      default:   g = GEN_WIDE;
    endcase
    return g;
  endfunction

  function automatic logic [LANE_W-1:0] lane_reverse(input logic [LANE_W-1:0] b);
    logic [LANE_W-1:0] r;
    for (int i = 0; i < LANE_W; i++) r[i] = b[LANE_W-1-i];
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] lane_condition(input logic [LANE_W-1:0] b,
                                                       input logic rev, input logic inv);
    logic [LANE_W-1:0] r;
    r = rev ? lane_reverse(b) : b;
    return inv ? ~r : r;
  endfunction

  function automatic logic [DATA_W-1:0] sum_reverse(input logic [DATA_W-1:0] v,
                                                    input logic [1:0] sel);
    logic [DATA_W-1:0] r;
    r = '0;
    if (sel_wide(sel)) begin
      for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    end else begin
      for (int i = 0; i < NARROW_W; i++) r[i] = v[NARROW_W-1-i];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] fold_lane(input logic [DATA_W-1:0] c_in,
                                                  input logic [LANE_W-1:0] b,
                                                  input logic [1:0] sel);
    logic [DATA_W-1:0] c, m, g;
    logic fb;
    m = sel_mask(sel);
    g = sel_gen(sel);
    c = c_in & m;
    for (int i = LANE_W-1; i >= 0; i--) begin
      fb = (sel_wide(sel) ? c[DATA_W-1] : c[NARROW_W-1]) ^ b[i];
      c  = (c << 1) & m;
      if (fb) c = c ^ g;
    end
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] extra_lanes(input logic [1:0] sz);
    logic [CNT_W-1:0] n;
    case (sz)
      SZ_ONE:  n = CNT_W'(0);
      SZ_TWO:  n = CNT_W'(1);
      default: n = CNT_W'(LANES-1);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/crc_lane_feeder.sv
module crc_lane_feeder
  import crc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort,
  input  logic                wr_valid,
  input  logic [1:0]          wr_size,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                din_rev,
  input  logic                din_inv,
  output logic                wr_ready,
  output logic                busy,
  output logic                fold_en,
  output logic [LANE_W-1:0]   fold_lane_o
);
  logic [CNT_W-1:0]  rem_q;
  logic [HOLD_W-1:0] hold_q;
  logic              accept;
  logic [LANE_W-1:0] raw_lane;

  assign busy     = (rem_q != '0);
  assign wr_ready = !busy && !abort;
  assign accept   = wr_valid && wr_ready;
  assign fold_en  = accept || (busy && !abort);
  assign raw_lane = busy ? hold_q[LANE_W-1:0] : wr_data[LANE_W-1:0];
  assign fold_lane_o = lane_condition(raw_lane, din_rev, din_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      hold_q <= '0;
    end else if (abort) begin
      rem_q  <= '0;
    end else if (accept) begin
      rem_q  <= extra_lanes(wr_size);
      hold_q <= wr_data[DATA_W-1:LANE_W];
    end else if (busy) begin
      rem_q  <= rem_q - CNT_W'(1);
      hold_q <= hold_q >> LANE_W;
    end
  end

  assert_full_word_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_size[1]) |=> (rem_q == CNT_W'(LANES-1)))
    else $error("R3: wide word did not load full pending count");

  assert_one_lane_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> (rem_q == $past(rem_q) - CNT_W'(1)))
    else $error("R3: pending count did not step by one");

  assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy)
    else $error("R5: seed load left bytes pending");

  assert_stalled_word_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy && !abort) |=> (busy || !accept || $past(rem_q) == CNT_W'(1)))
    else $error("R4: word accepted while bytes remained");
endmodule

// File: rtl/crc_lane_fold.sv
module crc_lane_fold
  import crc_pkg::*;
(
  input  logic [DATA_W-1:0] crc_in,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] crc_next
);
  assign crc_next = fold_lane(crc_in, lane, sel);
endmodule

// File: rtl/crc_readout.sv
module crc_readout
  import crc_pkg::*;
(
  input  logic [DATA_W-1:0] crc_q,
  input  logic [1:0]        sel,
  input  logic              sum_rev,
  input  logic              sum_inv,
  output logic [DATA_W-1:0] crc_out
);
  logic [DATA_W-1:0] masked, ordered;

  assign masked  = crc_q & sel_mask(sel);
  assign ordered = sum_rev ? sum_reverse(masked, sel) : masked;
  assign crc_out = sum_inv ? (ordered ^ sel_mask(sel)) : ordered;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_poly,
  input  logic        cfg_din_rev,
  input  logic        cfg_din_inv,
  input  logic        cfg_sum_rev,
  input  logic        cfg_sum_inv,
  input  logic        seed_we,
  input  logic [31:0] seed_val,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  output logic        busy,
  output logic [31:0] crc_out
);
  logic              fold_en;
  logic [LANE_W-1:0] fold_lane_w;
  logic [DATA_W-1:0] crc_q, crc_next;

  crc_lane_feeder u_feed (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (seed_we),
    .wr_valid   (wr_valid),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .din_rev    (cfg_din_rev),
    .din_inv    (cfg_din_inv),
    .wr_ready   (wr_ready),
    .busy       (busy),
    .fold_en    (fold_en),
    .fold_lane_o(fold_lane_w)
  );

  crc_lane_fold u_fold (
    .crc_in  (crc_q),
    .lane    (fold_lane_w),
    .sel     (cfg_poly),
    .crc_next(crc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (seed_we) crc_q <= seed_val & sel_mask(cfg_poly);
    else if (fold_en) crc_q <= crc_next;
  end

  crc_readout u_rd (
    .crc_q  (crc_q),
    .sel    (cfg_poly),
    .sum_rev(cfg_sum_rev),
    .sum_inv(cfg_sum_inv),
    .crc_out(crc_out)
  );

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && !fold_en) |=> $stable(crc_q))
    else $error("R10: checksum changed without fold or seed");

  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_poly[1] |-> (crc_out[31:16] == 16'h0000))
    else $error("R8: upper readout nonzero under 16-bit generator");

  assert_seed_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we && !cfg_poly[1]) |=> (crc_q[31:16] == 16'h0000))
    else $error("R5: narrow seed not masked");
endmodule

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_poly = 2'd0;
  logic        cfg_din_rev = 1'b0, cfg_din_inv = 1'b0, cfg_sum_rev = 1'b0, cfg_sum_inv = 1'b0;
  logic        seed_we = 1'b0;
  logic [31:0] seed_val = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_size = 2'd0;
  logic [31:0] wr_data = '0;
  logic        busy;
  logic [31:0] crc_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_crc = '0;

  always #10 clk = ~clk;

  crc_engine u_crc_engine (.*);

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(logic [1:0] p);
    return p[1] ? 32 : 16;
  endfunction

  function automatic logic [32:0] full_gen(logic [1:0] p);
    if (p == 2'd0) return 33'h0_0001_1021;
    if (p == 2'd1) return 33'h0_0001_8005;
    return 33'h1_04C1_1DB7;
  endfunction

  function automatic logic [31:0] wmask(logic [1:0] p);
    return p[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // bit-serial model: inject data at the top bit, shift, reduce by full generator
  function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] b);
    logic [32:0] r;
    logic [7:0] d;
    int w;
    w = width_of(cfg_poly);
    d = b;
    if (cfg_din_rev) for (int k = 0; k < 8; k++) d[k] = b[7-k];
    if (cfg_din_inv) d = ~d;
    r = {1'b0, c & wmask(cfg_poly)};
    for (int k = 7; k >= 0; k--) begin
      r = r ^ (33'(d[k]) << (w - 1));
      r = r << 1;
      if (r[w]) r = r ^ full_gen(cfg_poly);
    end
    return r[31:0] & wmask(cfg_poly);
  endfunction

  function automatic logic [31:0] ref_out(logic [31:0] c);
    logic [31:0] v, o;
    int w;
    w = width_of(cfg_poly);
    v = c & wmask(cfg_poly);
    o = v;
    if (cfg_sum_rev) begin
      o = '0;
      for (int k = 0; k < w; k++) o[k] = v[w-1-k];
    end
    if (cfg_sum_inv) o = o ^ wmask(cfg_poly);
    return o;
  endfunction

  function automatic int lanes_of(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic write_word(logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_size = sz; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
    for (int k = 0; k < lanes_of(sz); k++) m_crc = ref_byte(m_crc, d[8*k +: 8]);
  endtask

  task automatic seed_load(logic [31:0] v);
    @(negedge clk);
    seed_we = 1'b1; seed_val = v;
    @(posedge clk);
    #1 seed_we = 1'b0;
    m_crc = v & wmask(cfg_poly);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic set_cfg(logic [1:0] p, logic dr, logic di, logic sr, logic si);
    wait_idle();
    cfg_poly = p; cfg_din_rev = dr; cfg_din_inv = di; cfg_sum_rev = sr; cfg_sum_inv = si;
  endtask

  task automatic check_sum(string req);
    wait_idle();
    chk(req, crc_out, ref_out(m_crc));
    if (!cfg_poly[1]) chk("R8 upper half", {16'h0, crc_out[31:16]}, 32'h0);
  endtask

  task automatic check_value(string req, logic [31:0] exp);
    wait_idle();
    chk(req, crc_out, exp);
  endtask

  task automatic ascii_nine();
    write_word(2'd2, 32'h3433_3231);
    write_word(2'd2, 32'h3837_3635);
    write_word(2'd0, 32'hFFFF_FF39);
  endtask

  task automatic timing_case(logic [1:0] sz);
    int cnt;
    wait_idle();
    wr_valid = 1'b1; wr_size = sz; wr_data = $urandom;
    chk("R4 ready when idle", {31'h0, wr_ready}, 32'h1);
    @(posedge clk);
    #1 wr_valid = 1'b0;
    for (int k = 0; k < lanes_of(sz); k++) m_crc = ref_byte(m_crc, wr_data[8*k +: 8]);
    cnt = 0;
    @(negedge clk);
    while (busy) begin
      if (wr_ready) chk("R4 ready while busy", 32'h1, 32'h0);
      cnt++;
      @(negedge clk);
    end
    chk("R3 busy cycles", cnt, lanes_of(sz) - 1);
    chk("R3 fold result", crc_out, ref_out(m_crc));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset checksum", crc_out, 32'h0);
    chk("R9 reset busy", {31'h0, busy}, 32'h0);
    chk("R9 reset ready", {31'h0, wr_ready}, 32'h1);

    // R1 R6 R7 well-known check values over "123456789"
    set_cfg(2'd2, 1, 0, 1, 1); seed_load(32'hFFFF_FFFF); ascii_nine();
    check_value("R1 R6 R7 32-bit reflected", 32'hCBF4_3926);
    set_cfg(2'd0, 0, 0, 0, 0); seed_load(32'h0000_FFFF); ascii_nine();
    check_value("R1 R5 CCITT seed FFFF", 32'h0000_29B1);
    set_cfg(2'd1, 1, 0, 1, 0); seed_load(32'h0); ascii_nine();
    check_value("R1 R6 R7 16-bit reflected", 32'h0000_BB3D);
    // R2 byte order via 16-bit writes
    set_cfg(2'd0, 0, 0, 0, 0); seed_load(32'h0);
    write_word(2'd1, 32'hABCD_3231); write_word(2'd1, 32'h0000_3433);
    write_word(2'd1, 32'h0000_3635); write_word(2'd1, 32'h0000_3837);
    write_word(2'd0, 32'h0000_0039);
    check_value("R2 lsb-first 16-bit writes", 32'h0000_31C3);

    // R3 timing per size, R4 ready low during busy
    set_cfg(2'd2, 0, 0, 0, 0); seed_load(32'h1234_5678);
    timing_case(2'd0); timing_case(2'd1); timing_case(2'd2); timing_case(2'd3);
    set_cfg(2'd3, 0, 1, 0, 0);
    timing_case(2'd2);

    // R4 stall: second word offered right behind a 32-bit word
    set_cfg(2'd2, 1, 1, 0, 1); seed_load(32'hCAFE_F00D);
    write_word(2'd2, 32'h0102_0304);
    write_word(2'd1, 32'hFFFF_A55A);
    write_word(2'd0, 32'h0000_00C3);
    check_sum("R4 stalled words not lost");

    // R5 seed aborts pending bytes; R4 ready low during seed
    set_cfg(2'd2, 0, 0, 0, 0); seed_load(32'h0);
    write_word(2'd2, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R4 busy after wide accept", {31'h0, busy}, 32'h1);
    seed_we = 1'b1; seed_val = 32'h8765_4321;
    chk("R4 ready low during seed", {31'h0, wr_ready}, 32'h0);
    @(posedge clk);
    #1 seed_we = 1'b0;
    m_crc = 32'h8765_4321;
    @(negedge clk);
    chk("R5 busy cleared by seed", {31'h0, busy}, 32'h0);
    chk("R5 seed value loaded", crc_out, 32'h8765_4321);
    // R5 R8 narrow seed masked
    set_cfg(2'd1, 0, 0, 0, 0); seed_load(32'hFFFF_1357);
    @(negedge clk);
    chk("R5 R8 narrow seed masked", crc_out, 32'h0000_1357);
    // R10 register holds with no write
    repeat (5) @(negedge clk);
    chk("R10 idle hold", crc_out, 32'h0000_1357);

    // random mixed traffic vs model
    for (int it = 0; it < 160; it++) begin
      if (it % 12 == 0) begin
        set_cfg(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        seed_load($urandom);
      end
      write_word(2'($urandom_range(0, 3)), $urandom);
      if (it % 3 == 0) check_sum("R1 R2 R6 R7 random");
    end
    check_sum("R1 random final");

    summary();
  end
endmodule